// File: doc/BRIEF.md
# UART In-Band Flow Control Status Register

This block holds the software-visible state of XON/XOFF flow control for one UART channel and drives the control outputs that follow from it. Character matching happens elsewhere, so the receiver delivers one-cycle pulses when it decodes an XOFF, an XON or a special character. The transmitter pulses a strobe when it has sent an XOFF or an XON.

From these events the block keeps three sticky flags:

- a local halt flag, which inhibits the local transmitter;
- a remote halt flag, which records that the far end has been told to stop;
- a special-character flag.

It also assembles a byte-wide status word. The live bits of that word are the modem-pin readback, the transmitter idle state and a fixed FIFO-size indication.

Software writes zero to a halt flag to release it. Releasing the remote halt flag also schedules an XON character toward the far end. That request waits until the transmitter signals a free slot, and then the block emits it as a single-cycle pulse. Reading the status word clears the special-character flag. A channel soft-reset input returns the flow control state to idle without a full reset.

Top module: `uart_xfc_status`

## Requirements
- R1: A pulse on `rx_xoff_hit` sets status bit 0 and `tx_inhibit` on the next cycle; `tx_inhibit` always equals status bit 0.
- R2: A pulse on `rx_xon_hit` clears status bit 0 on the next cycle.
- R3: A pulse on `tx_sent_xoff` sets status bit 1 on the next cycle; a pulse on `tx_sent_xon` clears it.
- R4: A write (`reg_wr`) with `reg_wdata[0]`=0 clears bit 0. A write with `reg_wdata[1]`=0 clears bit 1, and if bit 1 was set it schedules one XON request.
- R5: A write with `reg_wdata[0]`=1 leaves bit 0 unchanged, and a write with `reg_wdata[1]`=1 leaves bit 1 unchanged.
- R6: A scheduled XON request is held while `xon_slot` is low. In the cycle after `xon_slot` is sampled high, `xon_req` is high for exactly one cycle. Writing 0 to bit 1 while bit 1 is clear schedules nothing.
- R7: A pulse on `soft_rst` clears bits 0 and 1 and any pending XON request on the next cycle; bit 4 is unaffected.
- R8: Outside loopback, bits 2 and 3 read as the inverse of `rts_n_level` and `dtr_n_level`. With `loopback`=1 they read `rts_flow_hold` and `dtr_flow_hold`.
- R9: A pulse on `rx_special_hit` sets bit 4. A cycle with `reg_rd` high clears it on the next cycle, unless a special character arrives in that same cycle.
- R10: Bit 5 reads 0, and bit 6 reads 1 exactly when parameter `FIFO_DEPTH` exceeds 16 (default 128 gives 1). Writes never change bits 7 to 2.
- R11: Bit 7 reads 1 exactly when both `tx_fifo_empty` and `tx_shift_empty` are high.
- R12: When a set event and a clearing cause reach bit 0, 1 or 4 in the same cycle, the flag ends set. `soft_rst` overrides a set on bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Channel soft reset pulse |
| rx_xoff_hit | input | 1 | Receiver decoded an XOFF character |
| rx_xon_hit | input | 1 | Receiver decoded an XON character |
| rx_special_hit | input | 1 | Receiver stored a special character |
| tx_sent_xoff | input | 1 | Transmitter sent an XOFF character |
| tx_sent_xon | input | 1 | Transmitter sent an XON character |
| xon_slot | input | 1 | Transmitter can accept an XON request |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rts_n_level | input | 1 | Level on the active-low RTS pin |
| dtr_n_level | input | 1 | Level on the active-low DTR pin |
| rts_flow_hold | input | 1 | Internal RTS flow control state (loopback readback) |
| dtr_flow_hold | input | 1 | Internal DTR flow control state (loopback readback) |
| loopback | input | 1 | Loopback mode |
| reg_wr | input | 1 | Status register write strobe |
| reg_rd | input | 1 | Status register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_status | output | 8 | Status word |
| tx_inhibit | output | 1 | Local transmitter halted |
| xon_req | output | 1 | One-cycle request to send an XON |

## Verification
The assertions watch every cycle for the single-edge rules:

- an XOFF event or a sent XOFF sets its flag next cycle;
- an XON event clears the local flag;
- writing ones leaves both halt flags alone;
- a soft reset empties both halt flags;
- `xon_req` never lasts two cycles;
- a read without a coincident special character clears bit 4;
- the transmitter inhibit only rises after an XOFF.

Some behaviours need the bench's scenarios instead:

- holding an XON request across several cycles of a busy transmitter and then issuing it once;
- the absence of a request when the remote flag was already clear;
- the readback of bits 2 and 3 across loopback switching;
- set-wins ordering when events and writes collide.

The bench shows these by comparing the whole status word against its reference model on every cycle.

// File: rtl/xfc_pkg.sv
// Package: shared bit positions and width of the flow control status word.
// Assumes software decodes the word by these fixed positions.
package xfc_pkg;
    localparam int STAT_W     = 8;
    localparam int B_LOC_HALT = 0;
    localparam int B_REM_HALT = 1;
    localparam int B_RTS      = 2;
    localparam int B_DTR      = 3;
    localparam int B_SPEC     = 4;
    localparam int B_RSVD     = 5;
    localparam int B_DEPTH    = 6;
    localparam int B_IDLE     = 7;
    localparam int DEEP_LIMIT = 16;

    typedef struct packed {
        logic loc_halt;
        logic rem_halt;
        logic spec;
    } xfc_flags_t;
endpackage

// File: rtl/xfc_sticky_flag.sv
// Sticky flag with a set event, a clear cause and an overriding flush.
// Assumes all inputs are synchronous to clk. SET_WINS picks the priority
// between set and clear when both arrive together.
module xfc_sticky_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set_ev,
    input  logic clr_ev,
    output logic q
);
    logic nxt;

    // Next-state selection with the configured set/clear priority.
    generate
        if (SET_WINS) begin : g_set_first
            always_comb begin
                nxt = q;
                if (clr_ev) nxt = 1'b0;
                if (set_ev) nxt = 1'b1;
                if (flush)  nxt = 1'b0;
            end
        end else begin : g_clr_first
            always_comb begin
                nxt = q;
                if (set_ev) nxt = 1'b1;
                if (clr_ev) nxt = 1'b0;
                if (flush)  nxt = 1'b0;
            end
        end
    endgenerate

    // Flag storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end
endmodule

// File: rtl/xfc_xon_sched.sv
// XON request scheduler: records a pending XON and issues it as a one-cycle
// pulse once the transmitter offers a slot. Assumes the transmitter takes
// the character in the same cycle it sees the pulse.
module xfc_xon_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic trigger,
    input  logic slot,
    output logic req
);
    logic pending;
    logic issue;

    // A request leaves the queue when a slot is offered while pending.
    always_comb issue = pending && slot && !flush;

    // Pending state: cleared on issue or flush, set by a new trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (flush) begin
            pending <= 1'b0;
        end else if (trigger) begin
            pending <= 1'b1;
        end else if (issue) begin
            pending <= 1'b0;
        end
    end

    // Registered single-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= issue;
    end
endmodule

// File: rtl/xfc_status_pack.sv
// Assembles the status word from stored flags and live inputs.
// Assumes the pin inputs are already synchronised to clk.
module xfc_status_pack
    import xfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 128
) (
    input  xfc_flags_t        flags,
    input  logic              rts_n_level,
    input  logic              dtr_n_level,
    input  logic              rts_flow_hold,
    input  logic              dtr_flow_hold,
    input  logic              loopback,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    output logic [STAT_W-1:0] status
);
    localparam bit DEEP = (FIFO_DEPTH > DEEP_LIMIT);

    logic depth_bit;

    // Fixed FIFO-size indication chosen by the depth parameter.
    generate
        if (DEEP) begin : g_deep
            assign depth_bit = 1'b1;
        end else begin : g_shallow
            assign depth_bit = 1'b0;
        end
    endgenerate

    // Bit-by-bit assembly of the readable word.
    always_comb begin
        status             = '0;
        status[B_LOC_HALT] = flags.loc_halt;
        status[B_REM_HALT] = flags.rem_halt;
        status[B_RTS]      = loopback ? rts_flow_hold : ~rts_n_level;
        status[B_DTR]      = loopback ? dtr_flow_hold : ~dtr_n_level;
        status[B_SPEC]     = flags.spec;
        status[B_RSVD]     = 1'b0;
        status[B_DEPTH]    = depth_bit;
        status[B_IDLE]     = tx_fifo_empty & tx_shift_empty;
    end
endmodule

// File: rtl/uart_xfc_status.sv
// Top: in-band flow control status register and control engine for one
// UART channel. Assumes character decode upstream delivers one-cycle pulses
// and that read and write strobes last one cycle per access.
module uart_xfc_status
    import xfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_xoff_hit,
    input  logic              rx_xon_hit,
    input  logic              rx_special_hit,
    input  logic              tx_sent_xoff,
    input  logic              tx_sent_xon,
    input  logic              xon_slot,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic              rts_n_level,
    input  logic              dtr_n_level,
    input  logic              rts_flow_hold,
    input  logic              dtr_flow_hold,
    input  logic              loopback,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_status,
    output logic              tx_inhibit,
    output logic              xon_req
);
    xfc_flags_t flags;
    logic       wr_rel_loc;
    logic       wr_rel_rem;
    logic       xon_trig;

    // Decode of the write-zero release requests for the two halt flags.
    always_comb begin
        wr_rel_loc = reg_wr && !reg_wdata[B_LOC_HALT];
        wr_rel_rem = reg_wr && !reg_wdata[B_REM_HALT];
        xon_trig   = wr_rel_rem && flags.rem_halt;
    end

    xfc_sticky_flag #(.SET_WINS(1'b1)) u_loc (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .set_ev(rx_xoff_hit), .clr_ev(rx_xon_hit || wr_rel_loc),
        .q(flags.loc_halt)
    );

    xfc_sticky_flag #(.SET_WINS(1'b1)) u_rem (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .set_ev(tx_sent_xoff), .clr_ev(tx_sent_xon || wr_rel_rem),
        .q(flags.rem_halt)
    );

    xfc_sticky_flag #(.SET_WINS(1'b1)) u_spec (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .set_ev(rx_special_hit), .clr_ev(reg_rd),
        .q(flags.spec)
    );

    xfc_xon_sched u_xon (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .trigger(xon_trig), .slot(xon_slot), .req(xon_req)
    );

    xfc_status_pack #(.FIFO_DEPTH(FIFO_DEPTH)) u_pack (
        .flags(flags),
        .rts_n_level(rts_n_level), .dtr_n_level(dtr_n_level),
        .rts_flow_hold(rts_flow_hold), .dtr_flow_hold(dtr_flow_hold),
        .loopback(loopback),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
        .status(reg_status)
    );

    // Transmit inhibit follows the local halt flag.
    always_comb tx_inhibit = flags.loc_halt;
endmodule

// File: rtl/uart_xfc_status_chk.sv
// Checker: temporal properties of the flow control status register.
module uart_xfc_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       rx_xoff_hit,
    input logic       rx_xon_hit,
    input logic       rx_special_hit,
    input logic       tx_sent_xoff,
    input logic       tx_sent_xon,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_status,
    input logic       tx_inhibit,
    input logic       xon_req
);
    p_xoff_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_xoff_hit && !soft_rst) |=> (reg_status[0] && tx_inhibit));

    p_inhibit_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> $past(rx_xoff_hit));

    p_xon_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_xon_hit && !rx_xoff_hit) |=> !reg_status[0]);

    p_remote_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sent_xoff && !soft_rst) |=> reg_status[1]);

    p_write_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ((reg_wdata & 8'h03) == 8'h03) && !soft_rst
         && !rx_xon_hit && !rx_xoff_hit && !tx_sent_xon && !tx_sent_xoff)
        |=> $stable(reg_status[1:0]));

    p_xon_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xon_req |=> !xon_req);

    p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reg_status[1:0] == 2'b00));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !rx_special_hit) |=> !reg_status[4]);

    p_special_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_special_hit |=> reg_status[4]);
endmodule

bind uart_xfc_status uart_xfc_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .rx_xoff_hit(rx_xoff_hit), .rx_xon_hit(rx_xon_hit),
    .rx_special_hit(rx_special_hit),
    .tx_sent_xoff(tx_sent_xoff), .tx_sent_xon(tx_sent_xon),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_status(reg_status), .tx_inhibit(tx_inhibit), .xon_req(xon_req)
);

// File: tb/uart_xfc_status_test.sv
module uart_xfc_status_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, rx_xoff_hit = 0, rx_xon_hit = 0, rx_special_hit = 0;
    logic tx_sent_xoff = 0, tx_sent_xon = 0, xon_slot = 0;
    logic tx_fifo_empty = 1, tx_shift_empty = 1;
    logic rts_n_level = 1, dtr_n_level = 1, rts_flow_hold = 0, dtr_flow_hold = 0;
    logic loopback = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_status;
    logic tx_inhibit, xon_req;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit m_loc, m_rem, m_spec, m_pend, m_req;

    uart_xfc_status uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .rx_xoff_hit(rx_xoff_hit), .rx_xon_hit(rx_xon_hit),
        .rx_special_hit(rx_special_hit),
        .tx_sent_xoff(tx_sent_xoff), .tx_sent_xon(tx_sent_xon),
        .xon_slot(xon_slot), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty), .rts_n_level(rts_n_level),
        .dtr_n_level(dtr_n_level), .rts_flow_hold(rts_flow_hold),
        .dtr_flow_hold(dtr_flow_hold), .loopback(loopback),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_status(reg_status), .tx_inhibit(tx_inhibit), .xon_req(xon_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model update at each rising edge from the inputs held then
    always @(posedge clk) begin
        bit n_loc, n_rem, n_spec, n_pend, n_req;
        if (!rst_n) begin
            m_loc = 0; m_rem = 0; m_spec = 0; m_pend = 0; m_req = 0;
        end else begin
            n_loc = m_loc; n_rem = m_rem; n_spec = m_spec; n_pend = m_pend;
            if (rx_xon_hit || (reg_wr && !reg_wdata[0])) n_loc = 0;   // R2 R4
            if (rx_xoff_hit) n_loc = 1;                                // R1 R12
            if (tx_sent_xon || (reg_wr && !reg_wdata[1])) n_rem = 0;  // R3 R4
            if (tx_sent_xoff) n_rem = 1;                               // R3 R12
            if (reg_rd) n_spec = 0;                                    // R9
            if (rx_special_hit) n_spec = 1;
            n_req = m_pend && xon_slot && !soft_rst;                   // R6
            if (n_req) n_pend = 0;
            if (reg_wr && !reg_wdata[1] && m_rem) n_pend = 1;
            if (soft_rst) begin n_loc = 0; n_rem = 0; n_pend = 0; end // R7
            m_loc = n_loc; m_rem = n_rem; m_spec = n_spec;
            m_pend = n_pend; m_req = n_req;
        end
    end

    function automatic string tag_of(int b);
        case (b)
            0: return "R1";
            1: return "R3";
            2, 3: return "R8";
            4: return "R9";
            5, 6: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Compare all outputs against the model away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp;
        if (rst_n && !done) begin
            exp = '0;
            exp[0] = m_loc; exp[1] = m_rem;
            exp[2] = loopback ? rts_flow_hold : ~rts_n_level;
            exp[3] = loopback ? dtr_flow_hold : ~dtr_n_level;
            exp[4] = m_spec; exp[5] = 1'b0; exp[6] = 1'b1;
            exp[7] = tx_fifo_empty & tx_shift_empty;
            vectors++;
            for (int b = 0; b < 8; b++)
                if (reg_status[b] !== exp[b]) begin
                    errors++;
                    $display("FAIL %s status bit %0d actual %b expected %b at %0t",
                             tag_of(b), b, reg_status[b], exp[b], $time);
                end
            if (tx_inhibit !== m_loc) begin
                errors++;
                $display("FAIL R1 tx_inhibit actual %b expected %b", tx_inhibit, m_loc);
            end
            if (xon_req !== m_req) begin
                errors++;
                $display("FAIL R6 xon_req actual %b expected %b", xon_req, m_req);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse(ref logic s);
        s = 1; step(); s = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
    endtask

    // Directed check of a single value with a named requirement
    task automatic expect_bit(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step();
        expect_bit(reg_status[1:0] == 2'b00 && !xon_req, 1'b1, "R7 reset state");
        // R1: XOFF received halts transmitter
        pulse(rx_xoff_hit); step();
        expect_bit(tx_inhibit, 1'b1, "R1 inhibit after XOFF");
        // R2: XON received releases it
        pulse(rx_xon_hit); step();
        expect_bit(reg_status[0], 1'b0, "R2 XON clears");
        // R5: writing ones has no effect
        pulse(rx_xoff_hit); pulse(tx_sent_xoff);
        wr(8'hFF); step();
        expect_bit(reg_status[0] & reg_status[1], 1'b1, "R5 write ones");
        // R10: writes to read-only bits ignored
        expect_bit(reg_status[5], 1'b0, "R10 reserved bit");
        // R4 and R6: release remote, slot withheld, then granted
        xon_slot = 0;
        wr(8'h01); step(4);
        expect_bit(reg_status[1], 1'b0, "R4 remote cleared");
        expect_bit(reg_status[0], 1'b1, "R4 local kept by one");
        expect_bit(xon_req, 1'b0, "R6 held while no slot");
        xon_slot = 1; step();
        expect_bit(xon_req, 1'b1, "R6 request issued");
        step();
        expect_bit(xon_req, 1'b0, "R6 single cycle");
        xon_slot = 0;
        // R6: releasing an already clear remote flag schedules nothing
        wr(8'h00); xon_slot = 1; step(3);
        expect_bit(xon_req, 1'b0, "R6 no request when clear");
        xon_slot = 0;
        // R3: sent XON clears remote flag
        pulse(tx_sent_xoff); pulse(tx_sent_xon); step();
        expect_bit(reg_status[1], 1'b0, "R3 sent XON clears");
        // R7: soft reset flushes flags and pending request, bit 4 kept
        pulse(rx_xoff_hit); pulse(tx_sent_xoff); pulse(rx_special_hit);
        wr(8'hFD);
        pulse(soft_rst); xon_slot = 1; step(2);
        expect_bit(reg_status[1:0] == 2'b00 && !xon_req, 1'b1, "R7 soft reset");
        expect_bit(reg_status[4], 1'b1, "R7 special kept");
        xon_slot = 0;
        // R9: read clears, read plus new special keeps
        rx_special_hit = 1; reg_rd = 1; step(); rx_special_hit = 0; reg_rd = 0;
        expect_bit(reg_status[4], 1'b1, "R9 read with new special");
        pulse(reg_rd);
        expect_bit(reg_status[4], 1'b0, "R9 read clears");
        // R12: set wins against write clear
        rx_xoff_hit = 1; reg_wdata = 8'h00; reg_wr = 1; step();
        rx_xoff_hit = 0; reg_wr = 0;
        expect_bit(reg_status[0], 1'b1, "R12 set wins");
        wr(8'h00);
        // R8: pin readback across loopback
        for (int i = 0; i < 16; i++) begin
            {loopback, rts_n_level, dtr_n_level, rts_flow_hold} = 4'(i);
            dtr_flow_hold = ~rts_flow_hold;
            step();
            expect_bit(reg_status[2], loopback ? rts_flow_hold : ~rts_n_level, "R8 rts");
        end
        // R11: idle combinations
        for (int i = 0; i < 4; i++) begin
            {tx_fifo_empty, tx_shift_empty} = 2'(i);
            step();
            expect_bit(reg_status[7], (i == 3), "R11 idle");
        end
        // Mixed stimulus; the model compares every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            rx_xoff_hit = (r[3:0] == 0); rx_xon_hit = (r[3:0] == 1);
            rx_special_hit = (r[7:4] == 2); tx_sent_xoff = (r[11:8] == 3);
            tx_sent_xon = (r[11:8] == 4); xon_slot = r[12];
            soft_rst = (r[19:13] == 0); reg_wr = (r[22:20] == 0);
            reg_wdata = r[31:24]; reg_rd = (r[23] && r[14]);
            loopback = r[15]; rts_n_level = r[16]; dtr_n_level = r[17];
            rts_flow_hold = r[18]; dtr_flow_hold = r[19];
            tx_fifo_empty = r[20]; tx_shift_empty = r[21];
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule